// File: doc/BRIEF.md
# UART auto-baud rate detector

This block calibrates a serial receiver to an unknown line rate. Software arms it by setting its enable. The block then waits for a falling start edge on the receive line and times a 0x55 sync character. It counts prescaled clock ticks from the first rising edge after the start bit to the fifth rising edge, which is the rising edge into the stop bit. That span is eight bit times, so it holds four low bits and four high bits, and any asymmetry between high and low levels averages out.

The tick prescaler is eight times slower than the baud clock that the two clock-mode bits would normally select. The number of ticks counted is therefore directly the divisor that the baud generator needs. When the fifth rising edge arrives, the block clears its own enable and raises a completion interrupt. It also raises a sticky flag if the counter wraps.

While the block is armed, it blocks the transmitter and rejects writes to the transmit register. The receive datapath uses the enable output to stay idle.

Top module: `uart_autobaud`

## Requirements
- R1: After reset, `abd_en`, `divisor`, `ovf_flag`, `rx_irq` and `tx_block` are all 0.
- R2: A pulse on `en_set` is accepted only while `async_mode`=1 and `wake_en`=0. When accepted, it sets `abd_en` and clears `divisor` on the next cycle. Otherwise it has no effect.
- R3: `divisor` ends as floor(8·T/P). T is the bit period in clocks. P = 2^(PRE_LOG2+s), where s is 4, 2, 2 or 0 for {`cfg_wide`,`cfg_fast`} = 00, 01, 10, 11. While the block is not armed, `divisor` does not change.
- R4: One cycle after the fifth rising edge of the 0x55 character is detected (the character is sent LSB first, after a low start bit), `abd_en` is 0 and `rx_irq` is 1.
- R5: `rx_irq` stays set until a pulse on `rd_data` clears it on the next cycle. A completion in the same cycle takes priority over the clear.
- R6: When the counter passes its all-ones value, it wraps to 0 and sets `ovf_flag`. Detection continues, and `abd_en` stays 1.
- R7: `ovf_flag` is sticky. Software sets it with `ovf_set` and clears it with `ovf_clr`. A hardware wrap takes priority over the clear.
- R8: `tx_block` equals `abd_en`. `tx_wr_ok` is `tx_wr` masked to 0 while the block is armed.
- R9: A pulse on `en_clr` without `en_set` aborts detection. `abd_en` drops, `divisor` keeps its value, and later edges do not raise `rx_irq`.
- R10: A pulse on `en_set` during detection restarts the sequence from the start-bit search, with `divisor` cleared.
- R11: If `async_mode` falls or `wake_en` rises during detection, the sequence aborts as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Receive line (idle high), synchronized inside |
| cfg_wide | input | 1 | 16-bit divisor mode select |
| cfg_fast | input | 1 | High-speed baud select |
| async_mode | input | 1 | Asynchronous mode active |
| wake_en | input | 1 | Wake-up mode active |
| en_set | input | 1 | Software write pulse setting the enable |
| en_clr | input | 1 | Software write pulse clearing the enable |
| ovf_set | input | 1 | Software set of the overflow flag |
| ovf_clr | input | 1 | Software clear of the overflow flag |
| rd_data | input | 1 | Read of the receive data register |
| tx_wr | input | 1 | Write request to the transmit data register |
| abd_en | output | 1 | Enable bit, cleared by hardware at completion |
| divisor | output | CNT_W | Measured divisor / live counter |
| ovf_flag | output | 1 | Sticky counter wrap flag |
| rx_irq | output | 1 | Completion interrupt |
| tx_block | output | 1 | Transmitter blocked |
| tx_wr_ok | output | 1 | Transmit write accepted |

## Verification
The bench builds the block with CNT_W=8 and PRE_LOG2=2. With these values the tick period is 64, 16 or 4 clocks, so random bit periods of a few dozen clocks exercise every clock mode quickly. A counter wrap is also within reach: a 160-clock bit period in the fastest mode gives 320 ticks. The checks on the wrap, the abort and the restart take only a few thousand cycles each.

// File: rtl/uart_autobaud.sv
module uart_autobaud #(
  parameter int CNT_W    = 16,
  parameter int PRE_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic             cfg_wide,
  input  logic             cfg_fast,
  input  logic             async_mode,
  input  logic             wake_en,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic             ovf_set,
  input  logic             ovf_clr,
  input  logic             rd_data,
  input  logic             tx_wr,
  output logic             abd_en,
  output logic [CNT_W-1:0] divisor,
  output logic             ovf_flag,
  output logic             rx_irq,
  output logic             tx_block,
  output logic             tx_wr_ok
);
  localparam int PW = PRE_LOG2 + 4;

  typedef enum logic [1:0] {S_IDLE, S_START, S_EDGE1, S_COUNT} st_t;

  st_t           st;
  logic [2:0]    rx_sh;
  logic [2:0]    edges;
  logic [PW-1:0] pre;
  logic [2:0]    extra;
  logic [PW-1:0] pre_max;
  logic          rise, fall, allowed, start_req, abort;
  logic          tick, done, wrap_eff;

  assign rise      = rx_sh[1] & ~rx_sh[2];
  assign fall      = ~rx_sh[1] & rx_sh[2];
  assign allowed   = async_mode & ~wake_en;
  assign start_req = en_set & allowed;
  assign abort     = abd_en & ((en_clr & ~en_set) | ~allowed);

  always_comb begin
    case ({cfg_wide, cfg_fast})
      2'b00:   extra = 3'd4;
      2'b11:   extra = 3'd0;
      default: extra = 3'd2;
    endcase
  end
  assign pre_max = {PW{1'b1}} >> (3'd4 - extra);

  assign tick     = (st == S_COUNT) & (pre == pre_max);
  assign done     = (st == S_COUNT) & rise & (edges == 3'd4) & ~start_req & ~abort;
  assign wrap_eff = tick & (&divisor) & ~start_req & ~abort;

  assign tx_block = abd_en;
  assign tx_wr_ok = tx_wr & ~abd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sh <= 3'b111;
    else        rx_sh <= {rx_sh[1:0], rx_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      abd_en  <= 1'b0;
      divisor <= '0;
      edges   <= '0;
      pre     <= '0;
    end else if (start_req) begin
      st      <= S_START;
      abd_en  <= 1'b1;
      divisor <= '0;
      edges   <= '0;
      pre     <= '0;
    end else if (abort) begin
      st     <= S_IDLE;
      abd_en <= 1'b0;
    end else begin
      case (st)
        S_START: if (fall) st <= S_EDGE1;
        S_EDGE1: if (rise) begin
          st    <= S_COUNT;
          edges <= 3'd1;
          pre   <= '0;
        end
        S_COUNT: begin
          pre <= tick ? '0 : pre + 1'b1;
          if (tick) divisor <= divisor + 1'b1;
          if (rise) edges <= edges + 1'b1;
          if (done) begin
            st     <= S_IDLE;
            abd_en <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ovf_flag <= 1'b0;
    else if (wrap_eff | ovf_set) ovf_flag <= 1'b1;
    else if (ovf_clr)            ovf_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_irq <= 1'b0;
    else if (done)    rx_irq <= 1'b1;
    else if (rd_data) rx_irq <= 1'b0;
  end

  // R2
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> abd_en && divisor == '0);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !abd_en && !start_req |=> $stable(divisor));
  // R4
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !abd_en && rx_irq);
  // R5
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !done |=> !rx_irq);
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_eff && !done |=> ovf_flag && abd_en && divisor == '0);
  // R7
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);
  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abd_en && $stable(divisor));
endmodule

// File: tb/uart_autobaud_bench.sv
module uart_autobaud_bench;
  localparam int CLK_P = 10;
  localparam int CW    = 8;
  localparam int PL    = 2;

  logic clk = 0, rst_n = 0, rx_in = 1;
  logic cfg_wide = 0, cfg_fast = 0, async_mode = 1, wake_en = 0;
  logic en_set = 0, en_clr = 0, ovf_set = 0, ovf_clr = 0, rd_data = 0, tx_wr = 0;
  logic abd_en, ovf_flag, rx_irq, tx_block, tx_wr_ok;
  logic [CW-1:0] divisor;

  int n_cmp = 0, n_bad = 0;
  bit summarized = 0;

  uart_autobaud #(.CNT_W(CW), .PRE_LOG2(PL)) u_uart_autobaud (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .cfg_wide(cfg_wide), .cfg_fast(cfg_fast),
    .async_mode(async_mode), .wake_en(wake_en), .en_set(en_set), .en_clr(en_clr),
    .ovf_set(ovf_set), .ovf_clr(ovf_clr), .rd_data(rd_data), .tx_wr(tx_wr),
    .abd_en(abd_en), .divisor(divisor), .ovf_flag(ovf_flag), .rx_irq(rx_irq),
    .tx_block(tx_block), .tx_wr_ok(tx_wr_ok));

  always #(CLK_P/2) clk = ~clk;

  function automatic int shift_of(int mode);
    case (mode)
      0: return PL + 4;
      3: return PL;
      default: return PL + 2;
    endcase
  endfunction
  function automatic int raw_ticks(int t, int mode);
    return (8 * t) >> shift_of(mode);
  endfunction
  function automatic int exp_div(int t, int mode);
    return raw_ticks(t, mode) % (1 << CW);
  endfunction
  function automatic int exp_ovf(int t, int mode);
    return (raw_ticks(t, mode) >= (1 << CW)) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summarized) begin
      summarized = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic arm();
    @(negedge clk) en_set = 1;
    @(negedge clk) en_set = 0;
  endtask

  task automatic send_frame(int t, int nbits, bit mid);
    bit v;
    for (int b = 0; b < nbits; b++) begin
      v = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : bit'((8'h55 >> (b - 1)) & 1);
      rx_in = v;
      if (b == 8 && mid) begin
        repeat (t / 2) @(negedge clk);
        chk("R6 ovf mid", int'(ovf_flag), 1);
        chk("R6 abd_en mid", int'(abd_en), 1);
        repeat (t - t / 2) @(negedge clk);
      end else if (b == 4) begin
        repeat (t / 2) @(negedge clk);
        tx_wr = 1;
        #1;
        chk("R8 tx_block", int'(tx_block), int'(abd_en));
        chk("R8 tx_wr_ok", int'(tx_wr_ok), int'(!abd_en));
        @(negedge clk) tx_wr = 0;
        repeat (t - t / 2 - 1) @(negedge clk);
      end else begin
        repeat (t) @(negedge clk);
      end
    end
    rx_in = 1;
  endtask

  task automatic set_mode(int mode);
    @(negedge clk);
    cfg_wide = mode[1];
    cfg_fast = mode[0];
  endtask

  task automatic measure(int t, int mode, bit mid, string tag);
    set_mode(mode);
    arm();
    repeat (5) @(negedge clk);
    send_frame(t, 10, mid);
    repeat (4) @(negedge clk);
    chk({tag, " R3 divisor"}, int'(divisor), exp_div(t, mode));
    chk({tag, " R4 abd_en"}, int'(abd_en), 0);
    chk({tag, " R4 rx_irq"}, int'(rx_irq), 1);
    chk({tag, " R6 ovf"}, int'(ovf_flag), exp_ovf(t, mode));
    @(negedge clk) rd_data = 1;
    @(negedge clk) rd_data = 0;
    chk({tag, " R5 irq clear"}, int'(rx_irq), 0);
    @(negedge clk) ovf_clr = 1;
    @(negedge clk) ovf_clr = 0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
      end
    end
  end

  initial begin
    int hold;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 abd_en", int'(abd_en), 0);
    chk("R1 divisor", int'(divisor), 0);
    chk("R1 ovf", int'(ovf_flag), 0);
    chk("R1 irq", int'(rx_irq), 0);
    chk("R1 tx_block", int'(tx_block), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    measure(40, 3, 0, "dir m3");
    measure(64, 0, 0, "dir m0");
    measure(37, 1, 0, "dir m1");
    measure(53, 2, 0, "dir m2");

    for (int i = 0; i < 20; i++) begin
      int t = 8 + int'($urandom % 90);
      int m = int'($urandom % 4);
      measure(t, m, 0, "rnd");
    end

    measure(160, 3, 1, "wrap");

    // R2: en_set ignored while wake-up mode is on
    hold = int'(divisor);
    wake_en = 1;
    arm();
    chk("R2 ignored abd_en", int'(abd_en), 0);
    chk("R2 ignored divisor", int'(divisor), hold);
    wake_en = 0;
    arm();
    chk("R2 armed abd_en", int'(abd_en), 1);
    chk("R2 armed divisor", int'(divisor), 0);

    // R9: abort keeps the divisor
    set_mode(3);
    arm();
    repeat (5) @(negedge clk);
    send_frame(40, 5, 0);
    @(negedge clk) en_clr = 1;
    @(negedge clk) en_clr = 0;
    hold = int'(divisor);
    chk("R9 abort abd_en", int'(abd_en), 0);
    send_frame(40, 10, 0);
    repeat (4) @(negedge clk);
    chk("R9 divisor kept", int'(divisor), hold);
    chk("R9 no irq", int'(rx_irq), 0);

    // R10: restart in the middle of a character
    arm();
    repeat (5) @(negedge clk);
    send_frame(30, 6, 0);
    repeat (10) @(negedge clk);
    measure(30, 3, 0, "R10 restart");

    // R11: asynchronous mode dropped during detection
    arm();
    repeat (5) @(negedge clk);
    send_frame(40, 4, 0);
    hold = int'(divisor);
    @(negedge clk) async_mode = 0;
    @(negedge clk) async_mode = 1;
    chk("R11 abort abd_en", int'(abd_en), 0);
    send_frame(40, 10, 0);
    repeat (4) @(negedge clk);
    chk("R11 no irq", int'(rx_irq), 0);

    // R7: software set and clear of the overflow flag
    @(negedge clk) ovf_set = 1;
    @(negedge clk) ovf_set = 0;
    chk("R7 sw set", int'(ovf_flag), 1);
    repeat (3) @(negedge clk);
    chk("R7 sticky", int'(ovf_flag), 1);
    @(negedge clk) ovf_clr = 1;
    @(negedge clk) ovf_clr = 0;
    chk("R7 sw clr", int'(ovf_flag), 0);

    // R8: writes accepted when idle
    tx_wr = 1;
    #1;
    chk("R8 idle accept", int'(tx_wr_ok), 1);
    tx_wr = 0;

    finish_run();
  end
endmodule